// File: doc/BRIEF.md
# Timer Channel Input Capture with Glitch Filter and Edge Divider

This block is the input half of one timer channel. An asynchronous pin is first brought into the clock domain by two flip-flops. A digital glitch filter then runs on sampling ticks from a programmable divider, and a state machine lets the filtered level change only after a run of equal samples. Rising edges of the filtered level are counted by an event divider. On every 1st, 2nd, 4th or 8th edge, the value on the external 16-bit counter bus is latched into the channel's shared capture/compare register and a sticky capture flag is raised.

Configuration comes in as register-style inputs:
- a 2-bit direction select, where 00 means the channel drives an output and any other value means it captures;
- a 4-bit filter code;
- a 2-bit edge-divider code;
- a channel enable.

While the channel is in output mode, software writes the compare value through the same register that captures use.

The filter machine has four states:
- `FLT_LO`: filtered low and stable.
- `FLT_UP`: filtered still low while a run of high samples is counted.
- `FLT_HI`: filtered high and stable.
- `FLT_DN`: filtered still high while a run of low samples is counted.

The filter transitions, all taken only on a sampling tick, are:
- `FLT_LO` to `FLT_UP` on a high sample, or straight to `FLT_HI` when N is 1.
- `FLT_UP` to `FLT_HI` when the run reaches N.
- `FLT_UP` back to `FLT_LO` on any low sample.
- `FLT_HI` and `FLT_DN` mirror these three transitions with the levels swapped.

The capture machine has two states:
- `CAP_IDLE`: the channel is disabled or in output mode. The edge count is held at zero.
- `CAP_ARMED`: edges are counted and captures are made.

`CAP_IDLE` goes to `CAP_ARMED` when the channel is enabled in input mode. It returns to `CAP_IDLE` as soon as that condition drops.

Top module: `icap_channel`

## Requirements
- R1: After reset the direction select reads 00, the edge-divider code reads 00, the capture/compare register reads 0, the capture flag is 0 and the filtered level is 0.
- R2: The input passes through two synchronizing flops. With filter code 0000 (no filtering, one sample per clock, N=1), the capture flag reads 1 four clock edges after the first edge that sees the input high, and still reads 0 after three.
- R3: Filter codes 0001, 0010 and 0011 sample on every clock and need N = 2, 4 and 8 equal samples. A high pulse of (N-1) clocks is rejected, and one of N+2 clocks is accepted.
- R4: Filter codes 0100 to 1111 sample once every D clocks with (D,N) equal to (2,6), (2,8), (4,6), (4,8), (8,6), (8,8), (16,5), (16,6), (16,8), (32,5), (32,6), (32,8) in code order. A pulse of (N-1)·D clocks is rejected, and one of N·D+2 clocks is accepted.
- R5: The filtered level changes only on the clock after a sampling tick. It changes only when the last N samples all show the new level, so a single disagreeing sample restarts the run.
- R6: Only rising edges of the filtered level are events. A falling edge never captures.
- R7: Edge-divider code 00, 01, 10 or 11 makes every 1st, 2nd, 4th or 8th event capture.
- R8: The event count returns to zero when the edge-divider code is written and while the channel is disabled.
- R9: A capture copies the counter bus into the capture/compare register and sets the flag. The flag stays 1 until a clear strobe. A capture in the same cycle as a clear leaves the flag at 1.
- R10: No capture happens while the channel enable is 0 or the direction select is 00.
- R11: A write to the direction select takes effect only while the channel enable is 0. Otherwise it is ignored.
- R12: A software write to the capture/compare register takes effect only when the direction select is 00. In input mode it is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chan_en | input | 1 | Channel enable |
| sel_wr | input | 1 | Write strobe for the direction select |
| sel_wdata | input | 2 | New direction select (00 output, else input) |
| psc_wr | input | 1 | Write strobe for the edge-divider code |
| psc_wdata | input | 2 | New edge-divider code |
| filt_code | input | 4 | Filter code (sampling divider and run length) |
| ccr_wr | input | 1 | Software write strobe for the capture/compare register |
| ccr_wdata | input | 16 | Compare value to write |
| flag_clr | input | 1 | Clears the capture flag |
| cnt_val | input | 16 | External counter value |
| raw_in | input | 1 | Asynchronous channel input |
| sel_q | output | 2 | Current direction select |
| psc_q | output | 2 | Current edge-divider code |
| filt_lvl | output | 1 | Filtered input level |
| ccr_q | output | 16 | Capture/compare register |
| cap_flag | output | 1 | Sticky capture flag |

## Verification
On every cycle, the assertions check the following:
- The filtered level moves only after a tick, and never on a sample that agrees with it.
- The event count stays below the divider limit, and is zero after a divider write.
- No capture occurs while the channel is disarmed.
- A new flag always carries the counter value of the capture cycle.
- The flag holds without a clear.
- The direction select and the register are locked in the right modes.

Only the bench scenarios can show the rest:
- the exact four-edge latency;
- the reject/accept boundary of each of the sixteen filter codes;
- the every-Nth capture pattern of each divider code;
- a clear colliding with a capture.

// File: rtl/icap_pkg.sv
package icap_pkg;

    typedef enum logic [1:0] {
        FLT_LO = 2'd0,
        FLT_UP = 2'd1,
        FLT_HI = 2'd2,
        FLT_DN = 2'd3
    } flt_state_t;

    typedef enum logic {
        CAP_IDLE  = 1'b0,
        CAP_ARMED = 1'b1
    } cap_state_t;

    localparam int EV_W   = 3;
    localparam int NEED_W = 4;

    // log2 of the sampling divider for a filter code
    function automatic logic [2:0] flt_div_log2(input logic [3:0] code);
        logic [2:0] r;
        unique case (code)
            4'd0, 4'd1, 4'd2, 4'd3:     r = 3'd0;
            4'd4, 4'd5:                 r = 3'd1;
            4'd6, 4'd7:                 r = 3'd2;
            4'd8, 4'd9:                 r = 3'd3;
            4'd10, 4'd11, 4'd12:        r = 3'd4;
            default:                    r = 3'd5;
        endcase
        return r;
    endfunction

    // consecutive equal samples required for a filter code
    function automatic logic [NEED_W-1:0] flt_need(input logic [3:0] code);
        logic [NEED_W-1:0] r;
        unique case (code)
            4'd0:                               r = 4'd1;
            4'd1:                               r = 4'd2;
            4'd2:                               r = 4'd4;
            4'd10, 4'd13:                       r = 4'd5;
            4'd4, 4'd6, 4'd8, 4'd11, 4'd14:     r = 4'd6;
            default:                            r = 4'd8;
        endcase
        return r;
    endfunction

    // index of the event that triggers a capture for an edge-divider code
    function automatic logic [EV_W-1:0] psc_last(input logic [1:0] code);
        logic [EV_W-1:0] r;
        unique case (code)
            2'd0:    r = 3'd0;
            2'd1:    r = 3'd1;
            2'd2:    r = 3'd3;
            default: r = 3'd7;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/icap_sync.sv
module icap_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], async_in};
    end

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/icap_filter.sv
module icap_filter
    import icap_pkg::*;
#(
    parameter int DIV_LOG2_MAX = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       smp_in,
    input  logic [3:0] code,
    output logic       filt_lvl
);
    localparam int DIV_W = DIV_LOG2_MAX;

    logic [DIV_W-1:0]  div_q;
    logic [DIV_W-1:0]  mask;
    logic              tick;
    logic [2:0]        lg;
    logic [NEED_W-1:0] need;
    logic [NEED_W-1:0] run_q, run_d, run_inc;
    flt_state_t        st_q, st_d;

    assign lg      = flt_div_log2(code);
    assign need    = flt_need(code);
    assign mask    = DIV_W'((32'd1 << lg) - 32'd1);
    assign tick    = ((div_q & mask) == mask);
    assign run_inc = run_q + NEED_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_q + DIV_W'(1);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= FLT_LO;
            run_q <= '0;
        end else begin
            st_q  <= st_d;
            run_q <= run_d;
        end
    end

    // next state
    always_comb begin
        st_d  = st_q;
        run_d = run_q;
        if (tick) begin
            unique case (st_q)
                FLT_LO: if (smp_in) begin
                    if (need == NEED_W'(1)) st_d = FLT_HI;
                    else begin st_d = FLT_UP; run_d = NEED_W'(1); end
                end
                FLT_UP: begin
                    if (!smp_in)            st_d = FLT_LO;
                    else if (run_inc == need) st_d = FLT_HI;
                    else                    run_d = run_inc;
                end
                FLT_HI: if (!smp_in) begin
                    if (need == NEED_W'(1)) st_d = FLT_LO;
                    else begin st_d = FLT_DN; run_d = NEED_W'(1); end
                end
                FLT_DN: begin
                    if (smp_in)             st_d = FLT_HI;
                    else if (run_inc == need) st_d = FLT_LO;
                    else                    run_d = run_inc;
                end
                default: st_d = FLT_LO;
            endcase
        end
    end

    // outputs
    always_comb begin
        unique case (st_q)
            FLT_HI, FLT_DN: filt_lvl = 1'b1;
            default:        filt_lvl = 1'b0;
        endcase
    end

    // R5: level only moves after a sampling tick
    assert_lvl_on_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(filt_lvl));

    // R5: a sample agreeing with the level never flips it
    assert_agree_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && (smp_in == filt_lvl)) |=> $stable(filt_lvl));
endmodule

// File: rtl/icap_event.sv
module icap_event
    import icap_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             filt_lvl,
    input  logic             arm_en,
    input  logic             out_mode,
    input  logic [1:0]       psc_code,
    input  logic             psc_wr,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic             ccr_wr,
    input  logic [CNT_W-1:0] ccr_wdata,
    input  logic             flag_clr,
    output logic [CNT_W-1:0] ccr_q,
    output logic             cap_flag
);
    cap_state_t      st_q, st_d;
    logic            prev_q;
    logic            rise;
    logic            fire;
    logic [EV_W-1:0] ev_q, ev_d, last;

    assign rise = filt_lvl & ~prev_q;
    assign last = psc_last(psc_code);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= CAP_IDLE;
            ev_q   <= '0;
            prev_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            ev_q   <= ev_d;
            prev_q <= filt_lvl;
        end
    end

    always_comb st_d = arm_en ? CAP_ARMED : CAP_IDLE;

    // outputs and edge counting
    always_comb begin
        fire = 1'b0;
        ev_d = ev_q;
        unique case (st_q)
            CAP_IDLE: ev_d = '0;
            CAP_ARMED: begin
                if (!arm_en || psc_wr) ev_d = '0;
                else if (rise) begin
                    if (ev_q == last) begin
                        fire = 1'b1;
                        ev_d = '0;
                    end else begin
                        ev_d = ev_q + EV_W'(1);
                    end
                end
            end
            default: ev_d = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ccr_q    <= '0;
            cap_flag <= 1'b0;
        end else begin
            if (fire)                     ccr_q <= cnt_val;
            else if (ccr_wr && out_mode)  ccr_q <= ccr_wdata;
            if (fire)          cap_flag <= 1'b1;
            else if (flag_clr) cap_flag <= 1'b0;
        end
    end

    assert_ev_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ev_q <= last);

    assert_psc_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        psc_wr |=> (ev_q == '0));

    assert_cap_value_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cap_flag) |-> (ccr_q == $past(cnt_val)));

    assert_flag_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_flag && !flag_clr) |=> cap_flag);

    assert_cap_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !arm_en |=> !$rose(cap_flag));

    assert_ccr_locked_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_mode && !fire) |=> $stable(ccr_q));
endmodule

// File: rtl/icap_channel.sv
module icap_channel
    import icap_pkg::*;
#(
    parameter int CNT_W        = 16,
    parameter int DIV_LOG2_MAX = 5,
    parameter int SYNC_STAGES  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             chan_en,
    input  logic             sel_wr,
    input  logic [1:0]       sel_wdata,
    input  logic             psc_wr,
    input  logic [1:0]       psc_wdata,
    input  logic [3:0]       filt_code,
    input  logic             ccr_wr,
    input  logic [CNT_W-1:0] ccr_wdata,
    input  logic             flag_clr,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic             raw_in,
    output logic [1:0]       sel_q,
    output logic [1:0]       psc_q,
    output logic             filt_lvl,
    output logic [CNT_W-1:0] ccr_q,
    output logic             cap_flag
);
    logic smp;
    logic arm_en;
    logic out_mode;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= 2'b00;
            psc_q <= 2'b00;
        end else begin
            if (sel_wr && !chan_en) sel_q <= sel_wdata;
            if (psc_wr)             psc_q <= psc_wdata;
        end
    end

    assign out_mode = (sel_q == 2'b00);
    assign arm_en   = chan_en && !out_mode;

    icap_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (raw_in),
        .sync_out (smp)
    );

    icap_filter #(.DIV_LOG2_MAX(DIV_LOG2_MAX)) u_filt (
        .clk      (clk),
        .rst_n    (rst_n),
        .smp_in   (smp),
        .code     (filt_code),
        .filt_lvl (filt_lvl)
    );

    icap_event #(.CNT_W(CNT_W)) u_evt (
        .clk       (clk),
        .rst_n     (rst_n),
        .filt_lvl  (filt_lvl),
        .arm_en    (arm_en),
        .out_mode  (out_mode),
        .psc_code  (psc_q),
        .psc_wr    (psc_wr),
        .cnt_val   (cnt_val),
        .ccr_wr    (ccr_wr),
        .ccr_wdata (ccr_wdata),
        .flag_clr  (flag_clr),
        .ccr_q     (ccr_q),
        .cap_flag  (cap_flag)
    );

    assert_sel_locked_R11: assert property (@(posedge clk) disable iff (!rst_n)
        chan_en |=> $stable(sel_q));
endmodule

// File: tb/tb_icap_channel.sv
`timescale 1ns/1ps
module tb_icap_channel;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        chan_en = 1'b0;
    logic        sel_wr = 1'b0;
    logic [1:0]  sel_wdata = 2'b00;
    logic        psc_wr = 1'b0;
    logic [1:0]  psc_wdata = 2'b00;
    logic [3:0]  filt_code = 4'd0;
    logic        ccr_wr = 1'b0;
    logic [15:0] ccr_wdata = 16'd0;
    logic        flag_clr = 1'b0;
    logic [15:0] cnt_val = 16'd0;
    logic        raw_in = 1'b0;
    logic [1:0]  sel_q, psc_q;
    logic        filt_lvl, cap_flag;
    logic [15:0] ccr_q;

    int n_run = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    icap_channel dut (
        .clk(clk), .rst_n(rst_n), .chan_en(chan_en),
        .sel_wr(sel_wr), .sel_wdata(sel_wdata),
        .psc_wr(psc_wr), .psc_wdata(psc_wdata),
        .filt_code(filt_code), .ccr_wr(ccr_wr), .ccr_wdata(ccr_wdata),
        .flag_clr(flag_clr), .cnt_val(cnt_val), .raw_in(raw_in),
        .sel_q(sel_q), .psc_q(psc_q), .filt_lvl(filt_lvl),
        .ccr_q(ccr_q), .cap_flag(cap_flag)
    );

    function automatic int exp_div(input int code);
        if (code < 4)  return 1;
        if (code < 6)  return 2;
        if (code < 8)  return 4;
        if (code < 10) return 8;
        if (code < 13) return 16;
        return 32;
    endfunction

    function automatic int exp_need(input int code);
        case (code)
            0: return 1;
            1: return 2;
            2: return 4;
            10, 13: return 5;
            4, 6, 8, 11, 14: return 6;
            default: return 8;
        endcase
    endfunction

    task automatic chk(input string req, input int got, input int exp);
        n_run++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input int w, input int gap);
        raw_in = 1'b1; cyc(w);
        raw_in = 1'b0; cyc(gap);
    endtask

    task automatic clrflag();
        flag_clr = 1'b1; cyc(1); flag_clr = 1'b0;
    endtask

    task automatic wsel(input logic [1:0] v);
        sel_wr = 1'b1; sel_wdata = v; cyc(1); sel_wr = 1'b0;
    endtask

    task automatic wpsc(input logic [1:0] v);
        psc_wr = 1'b1; psc_wdata = v; cyc(1); psc_wr = 1'b0;
    endtask

    task automatic wccr(input logic [15:0] v);
        ccr_wr = 1'b1; ccr_wdata = v; cyc(1); ccr_wr = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int unused_seed;
        int d, n;
        logic [15:0] v, held;
        unused_seed = $urandom(32'h0BADC0DE);

        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        // R1 reset state
        chk("R1 sel", sel_q, 0);
        chk("R1 psc", psc_q, 0);
        chk("R1 ccr", ccr_q, 0);
        chk("R1 flag", cap_flag, 0);
        chk("R1 filt", filt_lvl, 0);

        wsel(2'b01);
        chan_en = 1'b1;
        cyc(2);

        // R2 exact latency with code 0000
        cnt_val = 16'h1234;
        raw_in = 1'b1;
        cyc(3);
        chk("R2 not yet", cap_flag, 0);
        cyc(1);
        chk("R2 flag", cap_flag, 1);
        chk("R2 value", ccr_q, 16'h1234);
        cyc(2);
        // R6 falling edge does not capture
        clrflag();
        raw_in = 1'b0;
        cyc(10);
        chk("R6 fall", cap_flag, 0);

        // R3/R4 per-code boundaries
        for (int code = 0; code < 16; code++) begin
            filt_code = 4'(code);
            d = exp_div(code);
            n = exp_need(code);
            cyc(2*n*d + 10);
            clrflag();
            if (n > 1) begin
                pulse((n-1)*d, 2*n*d + 10);
                chk(code < 4 ? "R3 reject" : "R4 reject", cap_flag, 0);
            end
            v = 16'($urandom);
            cnt_val = v;
            pulse(n*d + 2, 2*n*d + 10);
            chk(code < 4 ? "R3 accept" : "R4 accept", cap_flag, 1);
            chk(code < 4 ? "R3 value" : "R4 value", ccr_q, v);
            clrflag();
        end

        // R5 a single low sample restarts the run (code 0010, N=4)
        filt_code = 4'd2;
        cyc(20);
        clrflag();
        raw_in = 1'b1; cyc(3);
        raw_in = 1'b0; cyc(1);
        raw_in = 1'b1; cyc(3);
        raw_in = 1'b0; cyc(20);
        chk("R5 restart", cap_flag, 0);
        chk("R5 level", filt_lvl, 0);

        // R7 divider codes
        filt_code = 4'd0;
        cyc(5);
        for (int p = 0; p < 4; p++) begin
            wpsc(2'(p));
            clrflag();
            for (int k = 1; k <= 10; k++) begin
                v = 16'($urandom);
                cnt_val = v;
                pulse(3, 6);
                chk("R7 every-nth", cap_flag, (k % (1 << p)) == 0 ? 1 : 0);
                if (cap_flag) begin
                    chk("R7 value", ccr_q, v);
                    clrflag();
                end
            end
        end

        // R8 divider write clears count
        wpsc(2'd2);
        pulse(3, 6); pulse(3, 6);
        wpsc(2'd2);
        pulse(3, 6); pulse(3, 6); pulse(3, 6);
        chk("R8 after write", cap_flag, 0);
        pulse(3, 6);
        chk("R8 fourth", cap_flag, 1);
        clrflag();
        // R8 disable clears count
        pulse(3, 6); pulse(3, 6);
        chan_en = 1'b0; cyc(2);
        chan_en = 1'b1; cyc(3);
        pulse(3, 6); pulse(3, 6); pulse(3, 6);
        chk("R8 after disable", cap_flag, 0);
        pulse(3, 6);
        chk("R8 fourth again", cap_flag, 1);

        // R9 flag holds, capture wins over clear
        wpsc(2'd0);
        cyc(20);
        chk("R9 hold", cap_flag, 1);
        cnt_val = 16'hBEEF;
        raw_in = 1'b1;
        cyc(3);
        flag_clr = 1'b1; cyc(1); flag_clr = 1'b0;
        chk("R9 collide flag", cap_flag, 1);
        chk("R9 collide value", ccr_q, 16'hBEEF);
        raw_in = 1'b0; cyc(6);
        clrflag();
        chk("R9 cleared", cap_flag, 0);

        // R10 disabled channel / output mode
        chan_en = 1'b0;
        held = ccr_q;
        cnt_val = 16'h0F0F;
        pulse(3, 8);
        chk("R10 disabled flag", cap_flag, 0);
        chk("R10 disabled value", ccr_q, held);
        wsel(2'b00);
        chan_en = 1'b1;
        pulse(3, 8);
        chk("R10 out-mode flag", cap_flag, 0);
        chk("R10 out-mode value", ccr_q, held);

        // R11 select write locked while enabled
        wsel(2'b01);
        chk("R11 locked", sel_q, 0);
        chan_en = 1'b0;
        wsel(2'b10);
        chk("R11 open", sel_q, 2);

        // R12 compare write only in output mode
        wccr(16'h5555);
        chk("R12 input-mode ignored", ccr_q, held);
        wsel(2'b00);
        wccr(16'hA5A5);
        chk("R12 output-mode write", ccr_q, 16'hA5A5);
        wsel(2'b01);
        chan_en = 1'b1;
        cyc(2);

        // random mix, R3/R4 limits
        for (int it = 0; it < 30; it++) begin
            int code, acc;
            code = int'($urandom % 16);
            filt_code = 4'(code);
            d = exp_div(code);
            n = exp_need(code);
            cyc(2*n*d + 10);
            clrflag();
            acc = (n == 1) ? 1 : int'($urandom % 2);
            v = 16'($urandom);
            cnt_val = v;
            if (acc == 1)
                pulse(n*d + 2 + int'($urandom % 8), 2*n*d + 10);
            else
                pulse(1 + int'($urandom % ((n-1)*d)), 2*n*d + 10);
            chk(code < 4 ? "R3 random" : "R4 random", cap_flag, acc);
            if (acc == 1) chk("R9 random value", ccr_q, v);
        end

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule